// File: doc/BRIEF.md
# Two-Level Alternating Request Arbiter

This block shares one bus-master engine among three requesters: a target-side request port and two DMA channels. Arbitration happens on two levels. The upper level decides between the target port and the DMA group as a whole. The lower level decides between the two DMA channels, and it acts only when the DMA group wins. Under heavy contention, the high-bandwidth DMA traffic is interleaved with the lighter target traffic. A requester that faces no competition is served back to back.

A new decision is made only when the engine is idle (no grant is outstanding) or when the engine reports on `done_i` that the current transaction has finished. The winner's grant is registered. It appears on the cycle after the decision and stays fixed until the transaction completes. Each priority pointer always ends up favouring the side that did not win the last decision it took part in. Contested requests therefore alternate, and a lone requester still wins every time.

Top module: `two_lvl_arb`

## Requirements
- R1: While `rst_n` is low, all grants are zero. After reset, the upper level favours the target port and the lower level favours DMA channel 0.
- R2: A decision is taken on a clock edge only if no grant is outstanding or `done_i` is high. If any request is present at a decision, a grant is active on the following cycle.
- R3: While a grant is outstanding and `done_i` is low, every grant output holds its value.
- R4: At most one of `gnt_tgt_o`, `gnt_dma_o[0]`, `gnt_dma_o[1]` is high in any cycle.
- R5: A grant issued by a decision goes only to a requester whose request line was high at that decision.
- R6: When the target port and at least one DMA channel request at the same decision, the side the upper pointer favours wins. The upper pointer then favours the other side.
- R7: When both DMA channels request and the DMA group wins, the channel the lower pointer favours is granted. The lower pointer then favours the other channel.
- R8: With all three requests held high from reset, successive grants run target, DMA0, target, DMA1, target, DMA0.
- R9: A requester that is the only one requesting is granted at every decision.
- R10: While only the target port requests, it is granted repeatedly. At the first decision after a DMA request appears, the DMA group is granted.
- R11: When the DMA group wins and only one channel requests, that channel is granted whatever the lower pointer says. The lower pointer then favours the other channel.
- R12: A decision taken with no request present leaves all grants at zero on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_tgt_i | input | 1 | Request from the target-side port |
| req_dma_i | input | 2 | Requests from DMA channel 0 (bit 0) and channel 1 (bit 1) |
| done_i | input | 1 | Engine reports that the current transaction finishes this cycle |
| gnt_tgt_o | output | 1 | Grant to the target-side port |
| gnt_dma_o | output | 2 | Grants to DMA channel 0 (bit 0) and channel 1 (bit 1) |

## Verification
The bench first holds full contention right after reset. A design that started on the wrong side, or that let the DMA pointer move on target wins, would not produce the target, DMA0, target, DMA1 pattern. Next, the bench runs the target port alone and then adds a single DMA channel. A design that advanced pointers only on contested wins, or that ignored the absent side, would keep granting the target port after the DMA request appeared. The bench also runs multi-cycle transactions to catch grants that change before `done_i`. Random requests with random lengths are compared against a behavioural model on every clock, which catches grants to stale requesters and grants that fail to drop when requests stop.

// File: rtl/arb2l_pkg.sv
package arb2l_pkg;
  localparam int DMA_CH  = 2;
  localparam int GNT_W   = DMA_CH + 1;
  localparam int SYNC_ST = 2;
  typedef enum logic {SIDE_TGT = 1'b0, SIDE_DMA = 1'b1} top_side_e;
  typedef enum logic {CH_ZERO = 1'b0, CH_ONE = 1'b1} dma_side_e;
endpackage

// File: rtl/arb2l_rst_sync.sv
module arb2l_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb shift_d = {shift_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/arb2l_alt_pick.sv
module arb2l_alt_pick (
  input  logic req_a,
  input  logic req_b,
  input  logic favour_b,
  output logic win_a,
  output logic win_b,
  output logic favour_b_nxt
);
  always_comb begin
    win_a = req_a & (~req_b | ~favour_b);
    win_b = req_b & (~req_a |  favour_b);
    if (win_a)      favour_b_nxt = 1'b1;
    else if (win_b) favour_b_nxt = 1'b0;
    else            favour_b_nxt = favour_b;
  end
endmodule

// File: rtl/arb2l_en_reg.sv
module arb2l_en_reg #(
  parameter int         WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nxt;

  always_comb q_nxt = en ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/two_lvl_arb.sv
module two_lvl_arb
  import arb2l_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tgt_i,
  input  logic [DMA_CH-1:0] req_dma_i,
  input  logic              done_i,
  output logic              gnt_tgt_o,
  output logic [DMA_CH-1:0] gnt_dma_o
);
  logic             rst_int_n;
  logic             dma_any;
  logic             busy;
  logic             decide;
  logic             tgt_win, grp_win;
  logic             ch0_win, ch1_win;
  logic             top_fav_q, top_fav_d;
  logic             dma_fav_q, dma_fav_d;
  logic [GNT_W-1:0] gnt_q, gnt_d;

  arb2l_rst_sync #(.STAGES(SYNC_ST)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  assign dma_any = |req_dma_i;
  assign busy    = |gnt_q;
  assign decide  = ~busy | done_i;

  // Upper level: target port (a) against DMA group (b)
  arb2l_alt_pick u_top_pick (
    .req_a(req_tgt_i), .req_b(dma_any), .favour_b(top_fav_q),
    .win_a(tgt_win), .win_b(grp_win), .favour_b_nxt(top_fav_d)
  );

  // Lower level: DMA channel 0 (a) against channel 1 (b)
  arb2l_alt_pick u_dma_pick (
    .req_a(req_dma_i[0]), .req_b(req_dma_i[1]), .favour_b(dma_fav_q),
    .win_a(ch0_win), .win_b(ch1_win), .favour_b_nxt(dma_fav_d)
  );

  always_comb gnt_d = {grp_win & ch1_win, grp_win & ch0_win, tgt_win};

  arb2l_en_reg #(.WIDTH(1), .RST_VAL(1'(SIDE_TGT))) u_top_fav (
    .clk(clk), .rst_n(rst_int_n), .en(decide),
    .d(top_fav_d), .q(top_fav_q)
  );

  arb2l_en_reg #(.WIDTH(1), .RST_VAL(1'(CH_ZERO))) u_dma_fav (
    .clk(clk), .rst_n(rst_int_n), .en(decide & grp_win),
    .d(dma_fav_d), .q(dma_fav_q)
  );

  arb2l_en_reg #(.WIDTH(GNT_W), .RST_VAL('0)) u_gnt (
    .clk(clk), .rst_n(rst_int_n), .en(decide),
    .d(gnt_d), .q(gnt_q)
  );

  assign gnt_tgt_o = gnt_q[0];
  assign gnt_dma_o = gnt_q[GNT_W-1:1];
endmodule

// File: rtl/two_lvl_arb_chk.sv
module two_lvl_arb_chk
  import arb2l_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_tgt_i,
  input logic [DMA_CH-1:0] req_dma_i,
  input logic              done_i,
  input logic              gnt_tgt_o,
  input logic [DMA_CH-1:0] gnt_dma_o
);
  logic [GNT_W-1:0] g, r;
  logic             dec;
  assign g   = {gnt_dma_o, gnt_tgt_o};
  assign r   = {req_dma_i, req_tgt_i};
  assign dec = (g == '0) || done_i;

  // R1
  always @(posedge clk) if (!rst_n) reset_clear_chk: assert (g == '0);

  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(g));

  // R3
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((g != '0) && !done_i) |=> $stable(g));

  // R5
  grant_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> ((g & ~$past(r)) == '0));

  // R12
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && (r == '0)) |=> (g == '0));

  // R9
  lone_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && (r == 3'b001)) |=> (g == 3'b001));
endmodule

bind two_lvl_arb two_lvl_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_tgt_i(req_tgt_i), .req_dma_i(req_dma_i),
  .done_i(done_i), .gnt_tgt_o(gnt_tgt_o), .gnt_dma_o(gnt_dma_o)
);

// File: tb/two_lvl_arb_tb.sv
module two_lvl_arb_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       req_tgt;
  logic [1:0] req_dma;
  logic       done;
  logic       gnt_tgt;
  logic [1:0] gnt_dma;

  int checks = 0;
  int errors = 0;
  int xlen   = 1;
  int cnt    = 0;
  string tag = "R1";

  two_lvl_arb u_dut (
    .clk(clk), .rst_n(rst_n), .req_tgt_i(req_tgt), .req_dma_i(req_dma),
    .done_i(done), .gnt_tgt_o(gnt_tgt), .gnt_dma_o(gnt_dma)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] gvec();
    return {gnt_dma, gnt_tgt};
  endfunction

  task automatic check(input string rq, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: grant actual=%b expected=%b at %0t", rq, act, exp, $time);
    end
  endtask

  // Behavioural reference: priority flags and expected grant
  int m_top_dma;   // 1 means DMA group favoured
  int m_ch1;       // 1 means channel 1 favoured
  logic [2:0] m_gnt;
  logic m_live;
  always @(posedge clk) begin
    int want_t, want_d, ch;
    if (!m_live) begin
      m_gnt <= 3'b000; m_top_dma <= 0; m_ch1 <= 0;
    end else if (m_gnt == 3'b000 || done) begin
      want_t = req_tgt;
      want_d = (req_dma != 2'b00);
      if (want_t && (!want_d || m_top_dma == 0)) begin
        m_gnt <= 3'b001; m_top_dma <= 1;
      end else if (want_d) begin
        m_top_dma <= 0;
        if (req_dma == 2'b11) ch = m_ch1;
        else                  ch = req_dma[1] ? 1 : 0;
        m_ch1 <= (ch == 0) ? 1 : 0;
        m_gnt <= (ch == 0) ? 3'b010 : 3'b100;
      end else begin
        m_gnt <= 3'b000;
      end
    end
  end

  // Engine stand-in: finishes each transaction after xlen cycles
  always @(negedge clk) begin
    if (!rst_n || gvec() == 3'b000) begin
      cnt = 0; done = 1'b0;
    end else begin
      if (done) cnt = 1; else cnt = cnt + 1;
      done = (cnt >= xlen);
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (m_live) check(tag, gvec(), m_gnt);
    if ($countones(gvec()) > 1) check("R4", gvec(), m_gnt);
  end

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] seq [6];
    logic [2:0] want [6];
    want = '{3'b001, 3'b010, 3'b001, 3'b100, 3'b001, 3'b010};
    m_live = 1'b0; rst_n = 1'b0; req_tgt = 1'b0; req_dma = 2'b00; done = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", gvec(), 3'b000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", gvec(), 3'b000);
    m_live = 1'b1;

    // R8 / R6 / R7 full contention from reset state
    tag = "R8"; xlen = 1;
    req_tgt = 1'b1; req_dma = 2'b11;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1 seq[i] = gvec();
    end
    for (int i = 0; i < 6; i++) check("R8", seq[i], want[i]);
    tag = "R6"; repeat (20) @(negedge clk);
    tag = "R7"; xlen = 3; repeat (30) @(negedge clk);

    // R9 / R10 target alone, then a DMA request appears
    tag = "R10"; req_dma = 2'b00; xlen = 2;
    repeat (12) @(negedge clk);
    check("R9", gvec(), 3'b001);
    req_dma = 2'b10;
    repeat (2) @(negedge clk);
    check("R10", gvec(), 3'b100);
    tag = "R11"; repeat (12) @(negedge clk);

    // R7 DMA channels only, multi-cycle transactions (R3)
    tag = "R3"; req_tgt = 1'b0; req_dma = 2'b11; xlen = 4;
    repeat (40) @(negedge clk);

    // R11 lone channel 0, then both again: pointer must favour channel 1
    tag = "R11"; req_dma = 2'b01; xlen = 1;
    repeat (6) @(negedge clk);
    check("R11", gvec(), 3'b010);
    req_dma = 2'b11;
    @(negedge clk);
    check("R11", gvec(), 3'b100);

    // R12 no requests
    tag = "R12"; req_dma = 2'b00;
    repeat (4) @(negedge clk);
    check("R12", gvec(), 3'b000);

    // R2 / R5 random traffic
    tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      req_tgt = $urandom_range(0, 1);
      req_dma = 2'($urandom_range(0, 3));
      if ((i % 50) == 0) xlen = $urandom_range(1, 5);
    end

    // R1 reset in the middle of traffic
    tag = "R1"; req_tgt = 1'b1; req_dma = 2'b11;
    @(negedge clk);
    rst_n = 1'b0; m_live = 1'b0;
    @(negedge clk);
    check("R1", gvec(), 3'b000);
    req_tgt = 1'b0; req_dma = 2'b00;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_live = 1'b1;
    tag = "R1"; req_tgt = 1'b1; req_dma = 2'b11; xlen = 1;
    @(negedge clk); #1 check("R1", gvec(), 3'b001);
    @(negedge clk); #1 check("R1", gvec(), 3'b010);
    req_tgt = 1'b0; req_dma = 2'b00;
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule